// File: doc/BRIEF.md
# Fragment-to-Host Block Delivery Engine

This engine moves a stream of 64-bit link words into host memory blocks that software set aside in advance. Software hands in blocks one at a time through a descriptor write port. Each descriptor gives a start address, a byte capacity and the number of the completion slot to fill. The engine queues up to 128 descriptors in arrival order. It writes link data straight into the current block and needs no processor action per transfer.

A block is handed back when its fragment ends or when the block fills. The engine then writes two 32-bit words into a completion slot in a host table of 128 two-word slots. The first word is the byte count and the second is a status word. Software writes 0xFFFFFFFF into a status word before it gives out the block, which marks the block as not yet returned. The engine writes 0x00000000 when the fragment closed without a trailing status beat. When a trailing status beat closed the fragment, the engine writes that beat's low 32 bits instead; the link source never sends 0x00000000 or 0xFFFFFFFF there. A fragment larger than its block spills into the next queued block. While no block is held, the link is stalled.

Top module: `frag_dma_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine returns after that edge with `lk_ready`, `err_size` and `err_ovf` all low.
- R2: `lk_ready` is low whenever the engine holds no block. Two clock edges after a descriptor is accepted into an empty engine, `lk_ready` is high.
- R3: The n-th data beat accepted into a block (n from 0) is written as one 64-bit write (`mem_w32`=0) to byte address start + 8·n, with `lk_data` unchanged.
- R4: A data beat with `lk_end`=1 closes the block. The byte count (8 per data beat) goes by a 32-bit write to RDY_BASE + 8·index, and status 0x00000000 goes by a 32-bit write to RDY_BASE + 8·index + 4.
- R5: A beat with `lk_stw`=1 closes the block. It is not written as data, and its `lk_data[31:0]` becomes the completion status.
- R6: The byte-count write of a completion comes in the clock cycle just before its status write, and the status write goes 4 bytes above it.
- R7: A block whose byte count reaches its capacity before the fragment ends is closed with count = capacity and status 0. The fragment continues at the start of the next descriptor, and descriptors are used in the order they were pushed.
- R8: A descriptor whose size is zero, is not a multiple of 8, or is above 2 MB (2097152 bytes) is discarded and sets the sticky `err_size` flag. A size of exactly 2 MB is accepted.
- R9: A valid descriptor pushed while 128 descriptors are queued is discarded and sets the sticky `err_ovf` flag.
- R10: Synchronous reset empties the descriptor queue and drops the held block, so `lk_ready` stays low afterwards until a new descriptor is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_wr | input | 1 | Descriptor push strobe |
| desc_addr | input | AW | Block start byte address |
| desc_size | input | SIZE_W | Block capacity in bytes |
| desc_idx | input | IW | Completion slot number for this block |
| lk_valid | input | 1 | Link beat present |
| lk_data | input | 64 | Link beat payload |
| lk_end | input | 1 | Data beat is the last of its fragment |
| lk_stw | input | 1 | Beat is a trailing status word that ends the fragment |
| lk_ready | output | 1 | Engine accepts the link beat |
| mem_wr | output | 1 | Host memory write strobe |
| mem_w32 | output | 1 | Write only `mem_data[31:0]` (completion words) |
| mem_addr | output | AW | Host byte address |
| mem_data | output | 64 | Host write data |
| err_size | output | 1 | Sticky: a descriptor with an illegal size was discarded |
| err_ovf | output | 1 | Sticky: a descriptor was discarded because the queue was full |

## Verification
A broken queue pointer or counter shows up at the ports within one fragment. Data lands in the wrong block, or a completion goes to the wrong slot, or `lk_ready` stays low although a descriptor was pushed. A wrong per-block byte counter shows in the very next data write address, and in the completion length written a cycle after the close. The state machine must pair each length write with a status write on the next cycle, so a state error appears as a lone or reordered completion word within two cycles of the closing beat.

// File: rtl/frag_dma_engine.sv
module frag_dma_engine #(
  parameter int AW = 32,
  parameter int SIZE_W = 32,
  parameter int FREE_DEPTH = 128,
  parameter int RDY_ENTRIES = 128,
  parameter int MAX_BLOCK = 2097152,
  parameter logic [AW-1:0] RDY_BASE = 32'h0010_0000,
  localparam int IW = $clog2(RDY_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_wr,
  input  logic [AW-1:0]     desc_addr,
  input  logic [SIZE_W-1:0] desc_size,
  input  logic [IW-1:0]     desc_idx,
  input  logic              lk_valid,
  input  logic [63:0]       lk_data,
  input  logic              lk_end,
  input  logic              lk_stw,
  output logic              lk_ready,
  output logic              mem_wr,
  output logic              mem_w32,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_data,
  output logic              err_size,
  output logic              err_ovf
);
  localparam int PW = $clog2(FREE_DEPTH);
  localparam int LW = $clog2(MAX_BLOCK) + 1;
  localparam int DW = AW + LW + IW;

  typedef enum logic [1:0] {S_DATA, S_LEN, S_STS} st_t;

  logic [DW-1:0] fifo [FREE_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  st_t           st;
  logic          have;
  logic [AW-1:0] b_addr;
  logic [LW-1:0] b_size, b_len;
  logic [IW-1:0] b_idx;
  logic [31:0]   b_sts;

  wire size_ok = desc_size != '0 && desc_size <= SIZE_W'(MAX_BLOCK) && desc_size[2:0] == 3'b000;
  wire full    = cnt == (PW+1)'(FREE_DEPTH);
  wire push    = desc_wr && size_ok && !full;
  wire pop     = !have && st == S_DATA && cnt != '0;
  wire beat    = lk_valid && lk_ready;
  wire [LW-1:0] nxt_len = b_len + LW'(8);
  wire [AW-1:0] ent_addr = RDY_BASE + AW'({b_idx, 3'b000});

  assign lk_ready = have && st == S_DATA;
  assign mem_wr   = (beat && !lk_stw) || st != S_DATA;
  assign mem_w32  = st != S_DATA;
  assign mem_addr = st == S_LEN ? ent_addr :
                    st == S_STS ? ent_addr + AW'(4) : b_addr + AW'(b_len);
  assign mem_data = st == S_LEN ? 64'(b_len) :
                    st == S_STS ? {32'b0, b_sts} : lk_data;

  always_ff @(posedge clk)
    if (push) fifo[wp] <= {desc_addr, desc_size[LW-1:0], desc_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      st <= S_DATA;
      have <= 1'b0;
      b_addr <= '0;
      b_size <= '0;
      b_len <= '0;
      b_idx <= '0;
      b_sts <= '0;
      err_size <= 1'b0;
      err_ovf <= 1'b0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop) begin
        rp <= rp + PW'(1);
        {b_addr, b_size, b_idx} <= fifo[rp];
        b_len <= '0;
        have <= 1'b1;
      end
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
      if (desc_wr && !size_ok) err_size <= 1'b1;
      if (desc_wr && size_ok && full) err_ovf <= 1'b1;
      case (st)
        S_DATA:
          if (beat) begin
            if (lk_stw) begin
              b_sts <= lk_data[31:0];
              st <= S_LEN;
            end else begin
              b_len <= nxt_len;
              b_sts <= '0;
              if (lk_end || nxt_len == b_size) st <= S_LEN;
            end
          end
        S_LEN: st <= S_STS;
        default: begin
          st <= S_DATA;
          have <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/frag_dma_engine_chk.sv
module frag_dma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          lk_stw,
  input logic          lk_ready,
  input logic          mem_wr,
  input logic          mem_w32,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_data,
  input logic          err_size,
  input logic          err_ovf
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!lk_ready && !err_size && !err_ovf)); // R1
  AST_DATA_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_w32) |-> (lk_valid && lk_ready && !lk_stw)); // R3
  AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_w32 && !mem_addr[2]) |-> mem_data[2:0] == 3'b000); // R4
  AST_LEN_THEN_STS: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_w32 && !mem_addr[2]) |=> (mem_wr && mem_w32 && mem_addr == $past(mem_addr) + AW'(4))); // R6
  AST_STS_AFTER_LEN: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_w32 && mem_addr[2]) |-> $past(mem_wr && mem_w32 && !mem_addr[2])); // R6
  AST_NO_READY_IN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    mem_w32 |-> !lk_ready); // R2
  AST_SIZE_STICKY: assert property (@(posedge clk) disable iff (rst) err_size |=> err_size); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) err_ovf |=> err_ovf); // R9
endmodule

bind frag_dma_engine frag_dma_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_stw(lk_stw), .lk_ready(lk_ready),
  .mem_wr(mem_wr), .mem_w32(mem_w32), .mem_addr(mem_addr), .mem_data(mem_data),
  .err_size(err_size), .err_ovf(err_ovf)
);

// File: tb/frag_dma_engine_test.sv
module frag_dma_engine_test;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic desc_wr = 1'b0;
  logic [31:0] desc_addr = '0, desc_size = '0;
  logic [6:0] desc_idx = '0;
  logic lk_valid = 1'b0, lk_end = 1'b0, lk_stw = 1'b0;
  logic [63:0] lk_data = '0;
  logic lk_ready, mem_wr, mem_w32, err_size, err_ovf;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;

  int checks = 0, errors = 0;
  int unsigned seq = 1;
  logic [31:0] mem [logic [31:0]];
  int unsigned wseq [logic [31:0]];

  always #5 clk = ~clk;

  frag_dma_engine uut (
    .clk(clk), .rst(rst), .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_size(desc_size),
    .desc_idx(desc_idx), .lk_valid(lk_valid), .lk_data(lk_data), .lk_end(lk_end),
    .lk_stw(lk_stw), .lk_ready(lk_ready), .mem_wr(mem_wr), .mem_w32(mem_w32),
    .mem_addr(mem_addr), .mem_data(mem_data), .err_size(err_size), .err_ovf(err_ovf)
  );

  always @(posedge clk) if (mem_wr) begin
    mem[mem_addr] = mem_data[31:0];
    wseq[mem_addr] = seq;
    if (!mem_w32) begin
      mem[mem_addr + 4] = mem_data[63:32];
      wseq[mem_addr + 4] = seq;
    end
    seq++;
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'hFFFF_FFFF;
  endfunction

  function automatic int unsigned ws(input logic [31:0] a);
    return wseq.exists(a) ? wseq[a] : 0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mem.delete();
    wseq.delete();
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] s, input logic [6:0] i);
    desc_wr = 1'b1; desc_addr = a; desc_size = s; desc_idx = i;
    @(negedge clk);
    desc_wr = 1'b0;
  endtask

  task automatic beat(input logic [63:0] d, input logic e, input logic w);
    lk_valid = 1'b1; lk_data = d; lk_end = e; lk_stw = w;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0; lk_end = 1'b0; lk_stw = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 lk_ready", lk_ready, 0);
    check("R1 err_size", err_size, 0);
    check("R1 err_ovf", err_ovf, 0);
  endtask

  task automatic t_backpressure();
    int unsigned s0;
    do_reset();
    s0 = seq;
    lk_valid = 1'b1; lk_data = 64'hDEAD;
    idle(5);
    check("R2 stalled without block", lk_ready, 0);
    check("R2 no write while stalled", seq, s0);
    lk_valid = 1'b0;
    push(32'h0000_1000, 64, 5);
    check("R2 not ready one edge after push", lk_ready, 0);
    idle(1);
    check("R2 ready two edges after push", lk_ready, 1);
  endtask

  task automatic t_plain();
    beat(64'h1111_2222_3333_4444, 0, 0);
    beat(64'h5555_6666_7777_8888, 0, 0);
    check("R4 status unloaded mid-fragment", rd(BASE + 40 + 4), 32'hFFFF_FFFF);
    beat(64'h9999_AAAA_BBBB_CCCC, 1, 0);
    idle(4);
    check("R3 beat0 lo", rd(32'h1000), 32'h3333_4444);
    check("R3 beat0 hi", rd(32'h1004), 32'h1111_2222);
    check("R3 beat2 lo", rd(32'h1010), 32'hBBBB_CCCC);
    check("R4 length", rd(BASE + 40), 24);
    check("R4 status zero", rd(BASE + 44), 0);
    check("R6 length before status", ws(BASE + 40) + 1, ws(BASE + 44));
    check("R2 released after close", lk_ready, 0);
  endtask

  task automatic t_stw();
    push(32'h0000_2000, 64, 9);
    beat(64'hA0A0_A0A0_A0A0_A0A0, 0, 0);
    beat(64'hB0B0_B0B0_B0B0_B0B0, 0, 0);
    beat(64'h0000_0000_1234_ABCD, 0, 1);
    idle(4);
    check("R5 length excludes status beat", rd(BASE + 72), 16);
    check("R5 status value", rd(BASE + 76), 32'h1234_ABCD);
    check("R5 status beat not stored", rd(32'h2010), 32'hFFFF_FFFF);
    check("R3 second beat", rd(32'h2008), 32'hB0B0_B0B0);
  endtask

  task automatic t_split();
    push(32'h0000_3000, 16, 1);
    push(32'h0000_4000, 64, 2);
    beat(64'h01, 0, 0);
    beat(64'h02, 0, 0);
    beat(64'h03, 1, 0);
    idle(4);
    check("R7 first block length", rd(BASE + 8), 16);
    check("R7 first block status", rd(BASE + 12), 0);
    check("R7 spill to next block start", rd(32'h4000), 3);
    check("R7 second block length", rd(BASE + 16), 8);
    check("R7 second block status", rd(BASE + 20), 0);
    check("R6 first before second", ws(BASE + 12) < ws(BASE + 16), 1);
  endtask

  task automatic t_size();
    do_reset();
    push(32'h0020_0000, 32'd2097152, 3);
    check("R8 2MB accepted", err_size, 0);
    beat(64'h77, 1, 0);
    idle(4);
    check("R8 2MB block used", rd(BASE + 24), 8);
    push(32'h0060_0000, 32'd2097160, 4);
    check("R8 oversize flagged", err_size, 1);
    push(32'h0000_5000, 8, 6);
    beat(64'h88, 1, 0);
    idle(4);
    check("R8 oversize not used", rd(BASE + 36), 32'hFFFF_FFFF);
    check("R8 next valid block used", rd(BASE + 48), 8);
    check("R8 flag sticky", err_size, 1);
    do_reset();
    push(32'h0000_6000, 12, 7);
    check("R8 size 12 flagged", err_size, 1);
    do_reset();
    push(32'h0000_6000, 0, 7);
    check("R8 size 0 flagged", err_size, 1);
    idle(3);
    check("R8 size 0 not queued", lk_ready, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 129; k++) push(32'h0010_0000 + k * 64, 64, 7'(k));
    check("R9 129 held without overflow", err_ovf, 0);
    push(32'h00F0_0000, 64, 0);
    check("R9 overflow flagged", err_ovf, 1);
    idle(2);
    check("R9 flag sticky", err_ovf, 1);
    do_reset();
    check("R10 flag cleared", err_ovf, 0);
    idle(4);
    check("R10 queue emptied", lk_ready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_backpressure();
    t_plain();
    t_stw();
    t_split();
    t_size();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule